// File: doc/BRIEF.md
# Restartable Whole-Register Vector Load/Store Sequencer

This block moves a whole group of vector registers between a small register file and a memory port. It ignores any configured vector length and any vector type setting. A single-cycle `start` supplies the instruction operands: a base address, the first register of the group, a 3-bit group field (the group holds field+1 registers), an element width code and a restart index. The block then issues memory requests one at a time. A load issues one request per element and writes each returned element into the register file. A store issues one request per byte, with the byte read from the register file, whatever width code is given.

The restart index counts elements (load) or bytes (store) from the start of the group. When the block starts with a non-zero index, it first finishes the rest of the partly done register and then moves the remaining registers. An `abort` input stops the sequence and keeps the index, so that a later `start` with that index picks up where the work stopped. When the group is complete, the index returns to zero and `done` pulses. A group whose first register is not a multiple of its size, or which runs past the last register, is refused with `illegal` and produces no traffic.

Top module: `vreg_whole_mover`

## Requirements
- R1: After reset `busy`, `done`, `illegal` and `mem_req` are 0 and `vstart_out` is 0.
- R2: A group is field+1 registers. For a load it holds (field+1)·16/esz elements, where esz = 1<<eew bytes (eew 0..3 stands for 8, 16, 32 and 64 bits). For a store it holds (field+1)·16 bytes. Exactly (total − restart index) transfers are made.
- R3: If `vreg` is not a multiple of field+1, or if `vreg`+field+1 exceeds 8, then `illegal` pulses in the cycle after `start`. No request is issued, the sequencer stays idle and `vstart_out` keeps its previous value.
- R4: A load request addresses base + idx·esz with `mem_size`=eew and `mem_we`=0. A store request addresses base + idx with `mem_size`=0 and `mem_we`=1, regardless of eew.
- R5: Transfer idx touches register `vreg` + (idx·esz)/16 at byte offset (idx·esz) mod 16. A load writes the low esz bytes of `mem_rdata` there, little-endian, with `rf_wsize`=eew. A store sends the byte read from there on `mem_wdata`.
- R6: Transfers begin at the restart index, so a partial first register is finished first. Elements below the index are left unchanged.
- R7: `vstart_out` increases by one when a store request is granted or a load response arrives, and otherwise holds while the sequencer is busy.
- R8: `done` is a one-cycle pulse in the cycle after the final transfer. In that cycle `vstart_out` is 0 and `busy` is 0.
- R9: If the restart index is at or above the total, `done` pulses in the cycle after `start`, `vstart_out` becomes 0 and no request is issued.
- R10: At most one request is outstanding: `mem_req` is low while a load response is awaited, and an ungranted request keeps its address.
- R11: `abort` while busy returns the sequencer to idle in the next cycle, with `vstart_out` frozen and no further requests. A later start with that index completes the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| store | input | 1 | 1 = store group, 0 = load group |
| base | input | AW | Base byte address |
| vreg | input | RW | First register of the group |
| nf | input | 3 | Group field; group holds nf+1 registers |
| eew | input | 2 | Element width code for loads (0..3 = 8..64 bits) |
| vstart_in | input | SW | Restart index to resume from |
| abort | input | 1 | Stop and keep the restart index |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a refused group |
| vstart_out | output | SW | Current restart index |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a byte write |
| mem_addr | output | AW | Request byte address |
| mem_size | output | 2 | log2 of access bytes |
| mem_wdata | output | 8 | Store byte |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Load response valid |
| mem_rdata | input | 64 | Load response data, little-endian |
| rf_we | output | 1 | Register file write enable |
| rf_wreg | output | RW | Write register index |
| rf_wbyte | output | LB | Write byte offset within register |
| rf_wsize | output | 2 | log2 of bytes written |
| rf_wdata | output | 64 | Write data |
| rf_rreg | output | RW | Read register index |
| rf_rbyte | output | LB | Read byte offset within register |
| rf_rdata | input | 8 | Byte read from the register file |

## Verification
Loads are run at all four element widths, across group sizes from one register to eight, and with restart indices of zero, mid-register and last element. This separates correct address scaling and register placement from an off-by-one in the partial-register path. Stores are run with a non-zero width code and confirm byte traffic. Refused groups are tried for both failure kinds: a misaligned register and a group that overruns the file. Restart indices at and above the total check the no-traffic path. Aborts are taken in the middle of a load and of a store, checked for a frozen index, and then resumed; the final memory and register file contents must match an uninterrupted run, while a memory with random grant and response gaps exercises the holding of requests.

// File: rtl/vreg_whole_mover.sv
module vreg_whole_mover #(
  parameter int AW    = 32,
  parameter int VLENB = 16,
  parameter int NREG  = 8,
  parameter int SW    = 16,
  localparam int LB   = $clog2(VLENB),
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          store,
  input  logic [AW-1:0] base,
  input  logic [RW-1:0] vreg,
  input  logic [2:0]    nf,
  input  logic [1:0]    eew,
  input  logic [SW-1:0] vstart_in,
  input  logic          abort,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [SW-1:0] vstart_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [7:0]    mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_wreg,
  output logic [LB-1:0] rf_wbyte,
  output logic [1:0]    rf_wsize,
  output logic [63:0]   rf_wdata,
  output logic [RW-1:0] rf_rreg,
  output logic [LB-1:0] rf_rbyte,
  input  logic [7:0]    rf_rdata
);
  localparam int BW = SW + 3;
  localparam int XW = RW + 4;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RESP} state_t;

  state_t        st;
  logic [SW-1:0] idx, total_q;
  logic [AW-1:0] base_q;
  logic [RW-1:0] vd_q;
  logic [1:0]    sh_q;
  logic          wr_q;

  logic [3:0]    len_in;
  logic [1:0]    sh_in;
  logic [SW-1:0] total_in;
  logic [XW-1:0] vx, lx;
  logic          bad;
  logic [BW-1:0] bidx;
  logic [RW-1:0] cur_reg;
  logic          last, adv;

  assign len_in   = {1'b0, nf} + 4'd1;
  assign sh_in    = store ? 2'd0 : eew;
  assign total_in = (SW'(len_in) << LB) >> sh_in;
  assign vx       = XW'(vreg);
  assign lx       = XW'(len_in);
  assign bad      = ((vx % lx) != '0) || ((vx + lx) > XW'(NREG));

  assign bidx     = BW'(idx) << sh_q;
  assign cur_reg  = vd_q + RW'(bidx >> LB);
  assign last     = (idx + SW'(1)) == total_q;

  assign busy       = st != S_IDLE;
  assign vstart_out = idx;

  assign mem_req   = st == S_REQ;
  assign mem_we    = wr_q;
  assign mem_addr  = base_q + AW'(bidx);
  assign mem_size  = sh_q;
  assign mem_wdata = rf_rdata;

  assign rf_rreg  = cur_reg;
  assign rf_rbyte = bidx[LB-1:0];
  assign rf_wreg  = cur_reg;
  assign rf_wbyte = bidx[LB-1:0];
  assign rf_wsize = sh_q;
  assign rf_wdata = mem_rdata;
  assign rf_we    = (st == S_RESP) && mem_rvalid && !abort;

  assign adv = !abort && (((st == S_REQ) && mem_gnt && wr_q) || rf_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      total_q <= '0;
      base_q  <= '0;
      vd_q    <= '0;
      sh_q    <= '0;
      wr_q    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad) begin
            illegal <= 1'b1;
          end else if (vstart_in >= total_in) begin
            idx  <= '0;
            done <= 1'b1;
          end else begin
            idx     <= vstart_in;
            total_q <= total_in;
            base_q  <= base;
            vd_q    <= vreg;
            sh_q    <= sh_in;
            wr_q    <= store;
            st      <= S_REQ;
          end
        end
        S_REQ: if (abort) begin
          st <= S_IDLE;
        end else if (mem_gnt) begin
          if (!wr_q) st <= S_RESP;
        end
        S_RESP: if (abort) begin
          st <= S_IDLE;
        end else if (mem_rvalid) begin
          st <= S_REQ;
        end
        default: st <= S_IDLE;
      endcase
      if (adv) begin
        if (last) begin
          idx  <= '0;
          done <= 1'b1;
          st   <= S_IDLE;
        end else begin
          idx <= idx + SW'(1);
        end
      end
    end
  end

  p_illegal_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !mem_req && !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && vstart_out == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv) |=> vstart_out == $past(vstart_out));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !last) |=> vstart_out == $past(vstart_out) + SW'(1));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !abort) |=> mem_req && $stable(mem_addr));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !busy && !mem_req && vstart_out == $past(vstart_out));

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> vstart_out < total_q);

endmodule

// File: tb/vreg_whole_mover_tb.sv
module vreg_whole_mover_tb;
  localparam int AW = 32, VLENB = 16, NREG = 8, SW = 16, LB = 4, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start = 0, store = 0, abort = 0;
  logic [AW-1:0] base = '0;
  logic [RW-1:0] vreg = '0;
  logic [2:0]    nf = '0;
  logic [1:0]    eew = '0;
  logic [SW-1:0] vstart_in = '0;
  logic          busy, done, illegal, mem_req, mem_we, rf_we;
  logic [SW-1:0] vstart_out;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size, rf_wsize;
  logic [7:0]    mem_wdata, rf_rdata;
  logic          mem_gnt = 0, mem_rvalid = 0;
  logic [63:0]   mem_rdata = '0, rf_wdata;
  logic [RW-1:0] rf_wreg, rf_rreg;
  logic [LB-1:0] rf_wbyte, rf_rbyte;

  vreg_whole_mover u_dut (.*);

  logic [7:0] rf [NREG*VLENB];
  logic [7:0] mem [256];
  logic [7:0] exp_rf [NREG*VLENB];
  logic [7:0] exp_mem [256];
  logic [AW-1:0] q[$];
  logic [15:0] lf = 16'hACE1;
  int total_chk = 0, bad_chk = 0;
  int exp_idx, nreq;

  assign rf_rdata = rf[int'(rf_rreg)*VLENB + int'(rf_rbyte)];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic build_exp(input bit st, input int b, input int vd, input int f, input int e, input int vs);
    int esz = st ? 1 : (1 << e);
    int tot = (f + 1) * VLENB / esz;
    for (int i = 0; i < NREG*VLENB; i++) exp_rf[i] = rf[i];
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    for (int k = vs; k < tot; k++)
      for (int j = 0; j < esz; j++) begin
        int bo = k*esz + j;
        if (st) exp_mem[(b + bo) & 255] = rf[vd*VLENB + bo];
        else    exp_rf[vd*VLENB + bo] = mem[(b + bo) & 255];
      end
  endtask

  task automatic compare(input string req);
    int nb = 0;
    for (int i = 0; i < NREG*VLENB; i++) if (rf[i] !== exp_rf[i]) nb++;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) nb++;
    chk(nb == 0, req, nb, 0);
  endtask

  task automatic run(input bit st, input int b, input int vd, input int f, input int e,
                     input int vs, input int abort_at, input bit exp_ill);
    int esz = st ? 1 : (1 << e);
    int tot = (f + 1) * VLENB / esz;
    int prev, n;
    @(negedge clk);
    prev = int'(vstart_out);
    store = st; base = b; vreg = vd[RW-1:0]; nf = f[2:0]; eew = e[1:0];
    vstart_in = vs[SW-1:0]; start = 1;
    exp_idx = vs; nreq = 0;
    @(negedge clk);
    start = 0;
    if (exp_ill) begin
      chk(illegal && !mem_req && !busy && int'(vstart_out) == prev, "R3 illegal", vstart_out, prev);
      repeat (3) begin
        @(negedge clk);
        chk(!mem_req && !busy && !illegal && !rf_we, "R3 quiet", mem_req, 0);
      end
      return;
    end
    if (vs >= tot) begin
      chk(done && !busy && vstart_out == 0 && !mem_req, "R9 beyond", vstart_out, 0);
      @(negedge clk);
      chk(!done && !mem_req, "R9 no traffic", done, 0);
      return;
    end
    n = 0;
    forever begin
      if (exp_idx == tot) begin
        chk(done && !busy && vstart_out == 0, "R8 done", done, 1);
        chk(nreq == tot - vs, "R2 transfer count", nreq, tot - vs);
        @(negedge clk);
        chk(!done, "R8 single pulse", done, 0);
        break;
      end
      chk(!done && busy && int'(vstart_out) == exp_idx, "R7 index", vstart_out, exp_idx);
      chk(!(mem_req && q.size() > 0), "R10 one outstanding", mem_req, 0);
      if (mem_req) begin
        chk(mem_addr == AW'(b + exp_idx*esz), "R4 address", mem_addr, b + exp_idx*esz);
        chk(mem_size == (st ? 2'd0 : e[1:0]) && mem_we == st, "R4 size/dir", mem_size, st ? 0 : e);
        if (st) chk(int'(rf_rreg) == vd + exp_idx/VLENB && int'(rf_rbyte) == exp_idx % VLENB,
                    "R5 store source", rf_rbyte, exp_idx % VLENB);
      end
      if (abort_at >= 0 && exp_idx == abort_at) begin
        abort = 1; mem_gnt = 0; mem_rvalid = 0; q.delete();
        @(negedge clk);
        abort = 0;
        chk(!busy && !mem_req && int'(vstart_out) == abort_at, "R11 abort freeze", vstart_out, abort_at);
        @(negedge clk);
        chk(!busy && !mem_req && int'(vstart_out) == abort_at, "R11 stays idle", vstart_out, abort_at);
        break;
      end
      mem_gnt = 0; mem_rvalid = 0;
      if (q.size() > 0 && lf[5]) begin
        for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem[(int'(q[0]) + k) & 255];
        mem_rvalid = 1;
        #1;
        chk(rf_we && rf_wsize == e[1:0] && int'(rf_wreg) == vd + (exp_idx*esz)/VLENB &&
            int'(rf_wbyte) == (exp_idx*esz) % VLENB, "R5 load placement", rf_wbyte, (exp_idx*esz) % VLENB);
        if (rf_we)
          for (int k = 0; k < (1 << rf_wsize); k++)
            rf[int'(rf_wreg)*VLENB + int'(rf_wbyte) + k] = rf_wdata[8*k +: 8];
        void'(q.pop_front());
        exp_idx++;
      end else if (mem_req && lf[0]) begin
        mem_gnt = 1;
        nreq++;
        if (st) begin
          mem[int'(mem_addr) & 255] = mem_wdata;
          exp_idx++;
        end else q.push_back(mem_addr);
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      n++;
      if (n > 3000) begin
        chk(0, "R8 completion timeout", n, 0);
        break;
      end
      @(negedge clk);
    end
    mem_gnt = 0; mem_rvalid = 0;
  endtask

  task automatic op(input bit st, input int b, input int vd, input int f, input int e, input int vs,
                    input string req);
    build_exp(st, b, vd, f, e, vs);
    run(st, b, vd, f, e, vs, -1, 0);
    compare(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG*VLENB; i++) rf[i] = 8'(i*13 + 5);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i*7 + 3);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !mem_req && vstart_out == 0, "R1 reset", vstart_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req && vstart_out == 0, "R1 after release", busy, 0);

    op(0, 8,  0, 0, 0, 0,  "R2 load e8 one reg");
    op(0, 40, 2, 1, 1, 0,  "R2 load e16 two regs");
    op(0, 64, 4, 3, 2, 5,  "R6 load e32 mid-register resume");
    op(0, 16, 0, 7, 3, 3,  "R6 load e64 eight regs resume");
    op(0, 90, 6, 1, 2, 7,  "R6 load last element only");
    op(1, 100, 6, 1, 0, 0, "R2 store two regs");
    op(1, 0,  0, 7, 3, 20, "R4 store ignores width code");

    run(0, 0, 3, 1, 0, 0, -1, 1);
    run(1, 0, 6, 3, 0, 0, -1, 1);
    run(0, 0, 6, 2, 0, 0, -1, 1);
    compare("R3 no side effects");

    build_exp(0, 0, 0, 0, 1, 8);
    run(0, 0, 0, 0, 1, 8, -1, 0);
    run(1, 0, 0, 0, 0, 200, -1, 0);
    compare("R9 nothing moved");

    build_exp(0, 32, 0, 1, 0, 0);
    run(0, 32, 0, 1, 0, 0, 10, 0);
    run(0, 0, 5, 1, 0, 0, -1, 1);
    chk(vstart_out == 10, "R3 index kept", vstart_out, 10);
    run(0, 32, 0, 1, 0, int'(vstart_out), -1, 0);
    compare("R11 load resume");

    build_exp(1, 150, 4, 3, 0, 0);
    run(1, 150, 4, 3, 0, 0, 7, 0);
    run(1, 150, 4, 3, 0, 7, 33, 0);
    run(1, 150, 4, 3, 0, int'(vstart_out), -1, 0);
    compare("R11 store resume twice");

    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule